// File: doc/BRIEF.md
# Threshold Zero-Suppression Data Packer

This block sits behind a multi-channel charge digitiser. For every event it accepts a stream of 64 charge values, one per channel in ascending channel order. It compares each value with a threshold that is held for that channel alone. Channels that survive are packed into self-describing 32-bit words. Each word carries the charge, the channel number, the module's geographic address and an even-parity bit. Suppression can be switched off, and then every channel is packed.

Both data paths are valid/ready streams. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, a presented word stays frozen and the input stalls. The block holds one surviving word back, so that it can tell whether that word is the last of its event. After the 64th beat of each event, the input pauses for one cycle while the final word is flushed.

An event in which no channel survives still produces exactly one word: an empty marker. Thresholds are written through a plain write port. The geographic address and the suppression enable are plain levels, sampled with each input beat.

Top module: `zsp_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every channel threshold is 0.
- R2: When `thr_we` is high at a clock edge, `thr_data` becomes the threshold of channel `thr_addr` and of no other channel. Beats accepted after that edge use the new value.
- R3: With `sup_en` = 1, a channel produces a word exactly when its charge is greater than or equal to its threshold. A charge equal to the threshold is kept.
- R4: With `sup_en` = 0, all 64 channels of an event produce a word, whatever their thresholds.
- R5: A data word has the charge in bits [12:0], the channel number in bits [18:13], the geographic address in bits [23:19] and zeros in bits [30:24].
- R6: Bit 31 of every output word makes the count of ones over all 32 bits even.
- R7: The n-th beat accepted within an event (counting from 0) is channel n. After channel 63 the count starts again at channel 0. Words leave in ascending channel order.
- R8: `out_last` is 1 on the final word of each event and 0 on every other word.
- R9: An event with no surviving channel emits one marker word with `out_last` = 1. The marker has bit 30 = 1, bits [29:24] = 0, channel field 63, charge 0, the event's geographic address in bits [23:19], and parity as in R6.
- R10: While `out_valid` = 1 and `out_ready` = 0, the word and `out_last` hold steady and `in_ready` is 0. `in_ready` is also 0 for the single flush cycle that follows the 64th beat of an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_en | input | 1 | 1 = drop channels below threshold |
| geo_addr | input | 5 | Module geographic address placed in each word |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | 6 | Channel whose threshold is written |
| thr_data | input | 13 | Threshold value |
| in_valid | input | 1 | Input charge beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_charge | input | 13 | Charge value of the current channel |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed output word |
| out_last | output | 1 | Final word of the event |

## Verification
The bench targets charges equal to, one below and above the threshold. A design that used a strict comparison would lose the equal channels. It also runs events where only channel 0 or only channel 63 survives. An off-by-one in the held-word flush would put `out_last` on the wrong word, or drop the final word. An event with every channel suppressed has to yield exactly one marker: a design that forgot the case would emit nothing and leave the consumer waiting for an event end. Pseudo-random back-pressure and an isolated single-channel threshold write catch words that change under a stall, beats accepted while the output is full, and writes that spill onto neighbouring channels.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
  localparam int CHG_W    = 13;
  localparam int CHN_W    = 6;
  localparam int GEO_W    = 5;
  localparam int WORD_W   = 32;
  localparam int CHN_LSB  = CHG_W;
  localparam int GEO_LSB  = CHG_W + CHN_W;
  localparam int PAD_LSB  = CHG_W + CHN_W + GEO_W;
  localparam int MARK_BIT = WORD_W - 2;

  typedef logic [WORD_W-1:0] word_t;

  // Build one output word; the top bit is chosen so the whole word has even parity.
  function automatic word_t pack_word(input logic mark, input logic [GEO_W-1:0] geo,
                                      input logic [CHN_W-1:0] ch, input logic [CHG_W-1:0] q);
    word_t w;
    w = '0;
    w[CHG_W-1:0]       = q;
    w[CHN_LSB +: CHN_W] = ch;
    w[GEO_LSB +: GEO_W] = geo;
    w[MARK_BIT]        = mark;
    w[WORD_W-1]        = ^w[WORD_W-2:0];
    return w;
  endfunction
endpackage

// File: rtl/zsp_thresh_mem.sv
module zsp_thresh_mem
  import zsp_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CHN_W-1:0] wr_addr,
  input  logic [CHG_W-1:0] wr_data,
  input  logic [CHN_W-1:0] rd_addr,
  output logic [CHG_W-1:0] rd_data
);
  logic [CHG_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < NUM_CH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_addr) < NUM_CH) ? mem[rd_addr] : '0;

  // R2: a write lands in the addressed entry
  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) < NUM_CH) |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/zsp_chan_seq.sv
module zsp_chan_seq
  import zsp_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CHN_W-1:0] ch,
  output logic             at_end
);
  localparam logic [CHN_W-1:0] LAST_CH = CHN_W'(NUM_CH - 1);

  assign at_end = (ch == LAST_CH);

  always_ff @(posedge clk) begin
    if (!rst_n)      ch <= '0;
    else if (step)   ch <= at_end ? '0 : ch + 1'b1;
  end

  // R7: channel advances by one per accepted beat and wraps after the last channel
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_end) |=> (ch == $past(ch) + 1'b1));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end) |=> (ch == '0));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ch));
endmodule

// File: rtl/zsp_word_emit.sv
module zsp_word_emit
  import zsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             keep,
  input  logic             end_evt,
  input  word_t            new_word,
  input  logic [GEO_W-1:0] geo,
  output logic             can_take,
  output logic             out_valid,
  input  logic             out_ready,
  output word_t            out_word,
  output logic             out_last
);
  logic  held_v;
  word_t held_w;
  logic  flush_q;
  logic [GEO_W-1:0] geo_q;
  logic  slot_free;

  assign slot_free = !out_valid || out_ready;
  assign can_take  = slot_free && !flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
      held_v    <= 1'b0;
      held_w    <= '0;
      flush_q   <= 1'b0;
      geo_q     <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        geo_q <= geo;
        if (keep) begin
          if (held_v) begin
            out_valid <= 1'b1;
            out_word  <= held_w;
            out_last  <= 1'b0;
          end
          held_w <= new_word;
          held_v <= 1'b1;
        end
        if (end_evt) flush_q <= 1'b1;
      end else if (flush_q && slot_free) begin
        out_valid <= 1'b1;
        out_last  <= 1'b1;
        out_word  <= held_v ? held_w : pack_word(1'b1, geo_q, '1, '0);
        held_v    <= 1'b0;
        flush_q   <= 1'b0;
      end
    end
  end

  // R10: a stalled word stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));
  // R6: every presented word has even parity
  p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_word) % 2 == 0));
  // R5: padding bits are zero on data words
  p_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_word[MARK_BIT]) |-> (out_word[MARK_BIT-1:PAD_LSB] == '0));
  // R9: a marker always closes its event
  p_marker_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[MARK_BIT]) |-> out_last);

  // R7: channels leave in ascending order inside an event
  logic             prev_v;
  logic [CHN_W-1:0] prev_ch;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v  <= 1'b0;
      prev_ch <= '0;
    end else if (out_valid && out_ready) begin
      prev_v  <= !out_last;
      prev_ch <= out_word[CHN_LSB +: CHN_W];
    end
  end
  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && prev_v) |-> (out_word[CHN_LSB +: CHN_W] > prev_ch));
endmodule

// File: rtl/zsp_packer.sv
module zsp_packer
  import zsp_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_en,
  input  logic [GEO_W-1:0]  geo_addr,
  input  logic              thr_we,
  input  logic [CHN_W-1:0]  thr_addr,
  input  logic [CHG_W-1:0]  thr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHG_W-1:0]  in_charge,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  logic [CHN_W-1:0] cur_ch;
  logic             at_end;
  logic [CHG_W-1:0] thr_rd;
  logic             take;
  logic             keep;
  word_t            beat_word;

  assign take      = in_valid && in_ready;
  assign keep      = !sup_en || (in_charge >= thr_rd);
  assign beat_word = pack_word(1'b0, geo_addr, cur_ch, in_charge);

  zsp_thresh_mem #(.NUM_CH(NUM_CH)) u_thr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(thr_we), .wr_addr(thr_addr), .wr_data(thr_data),
    .rd_addr(cur_ch), .rd_data(thr_rd)
  );

  zsp_chan_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(take), .ch(cur_ch), .at_end(at_end)
  );

  zsp_word_emit u_emit (
    .clk(clk), .rst_n(rst_n),
    .take(take), .keep(keep), .end_evt(at_end), .new_word(beat_word), .geo(geo_addr),
    .can_take(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_last(out_last)
  );

  // R10: no beat is taken while the output is blocked
  p_no_take_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !take);
  // R1: nothing is presented in the first cycle after reset
  p_reset_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

// File: tb/sim_zsp_packer.sv
module sim_zsp_packer;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup_en = 1'b0;
  logic [4:0]  geo_addr = '0;
  logic        thr_we = 1'b0;
  logic [5:0]  thr_addr = '0;
  logic [12:0] thr_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [12:0] in_charge = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_last;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";
  int stall_mode = 0;
  logic [15:0] lf = 16'hACE1;

  int thr_m [N];
  int ev [N];
  logic [31:0] exp_w [$];
  logic        exp_l [$];

  zsp_packer u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] mk_word(bit mark, int geo, int ch, int q);
    logic [30:0] body;
    body = {mark, 6'b0, 5'(geo), 6'(ch), 13'(q)};
    return {^body, body};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // back-pressure generator
  always @(negedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready <= (stall_mode == 0) ? 1'b1 : (lf[0] | lf[3]);
  end

  // output monitor
  logic        prev_hold = 1'b0;
  logic [31:0] prev_w = '0;
  logic        prev_l = 1'b0;
  always begin
    @(negedge clk); #3;
    if (rst_n) begin
      if (prev_hold)
        chk(out_valid && out_word == prev_w && out_last == prev_l, "R10", "stalled word moved",
            out_word, prev_w);
      if (out_valid && !out_ready)
        chk(!in_ready, "R10", "in_ready during stall", in_ready, 0);
      if (out_valid && out_ready) begin
        chk(^out_word == 1'b0, "R6", "parity", out_word, 0);
        if (exp_w.size() == 0) begin
          chk(0, cur_req, "unexpected word", out_word, 0);
        end else begin
          logic [31:0] ew;
          logic el;
          ew = exp_w.pop_front();
          el = exp_l.pop_front();
          chk(out_word == ew, cur_req, "word (R5 R7)", out_word, ew);
          chk(out_last == el, cur_req, "last flag (R8)", out_last, el);
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_w = out_word;
      prev_l = out_last;
    end
  end

  task automatic wr_thr(int ch, int val);
    @(negedge clk);
    thr_we = 1'b1; thr_addr = 6'(ch); thr_data = 13'(val);
    @(negedge clk);
    thr_we = 1'b0;
    thr_m[ch] = val;
  endtask

  task automatic run_event(bit sup, int geo, string req);
    int li;
    bit acc;
    int i;
    cur_req = req;
    sup_en = sup;
    geo_addr = 5'(geo);
    li = -1;
    for (int c = 0; c < N; c++) if (!sup || ev[c] >= thr_m[c]) li = c;
    for (int c = 0; c < N; c++)
      if (!sup || ev[c] >= thr_m[c]) begin
        exp_w.push_back(mk_word(0, geo, c, ev[c]));
        exp_l.push_back(c == li);
      end
    if (li < 0) begin
      exp_w.push_back(mk_word(1, geo, 63, 0));
      exp_l.push_back(1'b1);
    end
    @(negedge clk);
    in_valid = 1'b1; in_charge = 13'(ev[0]); i = 0;
    while (i < N) begin
      #2; acc = in_ready;
      @(negedge clk);
      if (acc) begin
        i++;
        if (i < N) in_charge = 13'(ev[i]);
      end
    end
    in_valid = 1'b0;
    for (int k = 0; k < 3000 && exp_w.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_w.size() == 0, req, "words missing at event end", exp_w.size(), 0);
    exp_w.delete(); exp_l.delete();
  endtask

  task automatic t_reset();
    #4;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    for (int c = 0; c < N; c++) ev[c] = 0;
    run_event(1, 3, "R1");   // zero thresholds keep zero charges
  endtask

  task automatic t_passthru();
    for (int c = 0; c < N; c++) wr_thr(c, 8191);
    for (int c = 0; c < N; c++) ev[c] = c * 100;
    run_event(0, 9, "R4");
  endtask

  task automatic t_suppress();
    for (int c = 0; c < N; c++) wr_thr(c, c * 50 + 1);
    for (int c = 0; c < N; c++)
      case (c % 3)
        0: ev[c] = thr_m[c] - 1;
        1: ev[c] = thr_m[c];
        default: ev[c] = thr_m[c] + 7;
      endcase
    run_event(1, 17, "R3");
  endtask

  task automatic t_empty();
    for (int c = 0; c < N; c++) wr_thr(c, 100);
    for (int c = 0; c < N; c++) ev[c] = 5;
    run_event(1, 21, "R9");
  endtask

  task automatic t_edges();
    for (int c = 0; c < N; c++) ev[c] = 5;
    ev[63] = 4000;
    run_event(1, 1, "R8");
    for (int c = 0; c < N; c++) ev[c] = 5;
    ev[0] = 100;
    run_event(1, 2, "R8");
  endtask

  task automatic t_isolate();
    for (int c = 0; c < N; c++) wr_thr(c, 200);
    wr_thr(17, 10);
    for (int c = 0; c < N; c++) ev[c] = 50;
    run_event(1, 6, "R2");
  endtask

  task automatic t_geo();
    for (int c = 0; c < N; c++) ev[c] = 8191 - c;
    run_event(0, 5'h15, "R5");
  endtask

  task automatic t_stall();
    stall_mode = 1;
    for (int c = 0; c < N; c++) wr_thr(c, (c * 37) % 300);
    for (int c = 0; c < N; c++) ev[c] = (c * 53) % 300;
    run_event(1, 11, "R10");
    run_event(0, 12, "R7");
    for (int c = 0; c < N; c++) ev[c] = 0;
    ev[0] = 299;
    run_event(1, 13, "R10");
    stall_mode = 0;
  endtask

  initial begin
    for (int c = 0; c < N; c++) thr_m[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_suppress();
    t_empty();
    t_edges();
    t_isolate();
    t_geo();
    t_stall();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule